// File: doc/BRIEF.md
# Maskable interrupt flag controller

This block keeps, for a set of interrupt sources, three flag banks side by side: a request flag, a mask flag and a priority flag per source. A request flag is set when its peripheral sends a one-cycle event pulse, or when software writes it. It is cleared by software, or automatically when the CPU acknowledges that source. One request bit position serves two peripherals. An event from either sets it, and the mask and priority bits at that position govern both.

The CPU reaches the flags through a 16-bit register port. Each bank is organised as 16-bit words, and each word has two byte lanes. A word, one byte, or single bits can be changed through load, bit-set and bit-clear write modes. From the unmasked pending sources the block picks a winner in two priority levels and presents a registered interrupt line, a high-level indicator and the winner's index. A one-cycle acknowledge strobe captures the winner and clears its flag.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all request flags are 0, all mask flags are 1, all priority flags are 0, and irq_o, irq_hi_o and ack_valid_o are 0.
- R2: A 1 on evt_i[i] sets request flag i at the next clock edge, and a 1 on evt_alt_i sets request flag SHARED_IDX (default 16).
- R3: addr_i is {bank[1:0], word}. Bank 0 is request, bank 1 is mask, bank 2 is priority. Word w holds flags 16w to 16w+15. wr_be_i[0] enables data bits 7:0 and wr_be_i[1] enables data bits 15:8. A byte whose enable is 0 keeps its value.
- R4: wr_mode_i selects how a write changes the enabled bytes. 0 loads wdata_i, 1 sets the bits where wdata_i is 1, 2 clears the bits where wdata_i is 1, and 3 changes nothing.
- R5: rd_en_i makes rdata_o, one cycle later, hold the selected word as it stood before that edge. A request set by an event in the read cycle appears only in a later read.
- R6: A source is pending when its request flag is 1 and its mask flag is 0. irq_o is 1 one cycle after any source becomes pending.
- R7: A priority flag of 1 marks a source as high level. irq_hi_o is 1 when a high-level source is pending. vec_o is the lowest pending high-level index, otherwise the lowest pending index, and 0 when nothing is pending.
- R8: When an event and a software clear hit the same request flag in the same cycle, the flag ends up 1.
- R9: An acknowledge strobe while something is pending clears the winner's request flag and, one cycle later, drives ack_valid_o to 1 with ack_idx_o equal to that winner. With nothing pending, ack_valid_o stays 0 and no flag changes.
- R10: When an acknowledge and an event hit the same request flag in the same cycle, the flag stays 1.
- R11: The mask and priority bits at SHARED_IDX act for both sources of that position. One acknowledge of SHARED_IDX clears the request even if both sources raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC (32) | Peripheral event pulses, one per flag |
| evt_alt_i | input | 1 | Event pulse of the second source sharing flag SHARED_IDX |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (3) | {bank, word} register address |
| wr_be_i | input | 2 | Byte lane enables |
| wr_mode_i | input | 2 | Write mode: load, set bits, clear bits, none |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| irq_o | output | 1 | Some source is pending |
| irq_hi_o | output | 1 | A high-level source is pending |
| vec_o | output | IDX_W (5) | Index of the current winner |
| ack_valid_o | output | 1 | Acknowledge captured a winner |
| ack_idx_o | output | IDX_W (5) | Index captured at the last acknowledge |

## Verification
A vector table tries the selection logic with several patterns. These include a single lone request, two requests where only the higher one is high level, requests at both ends of the index range, fully masked requests, a shared-position high request beating a lower index, and a masked high request beside an unmasked low one. Together they separate level ordering from index ordering and show that masking comes before priority. Directed sequences then place an event in the same cycle as a software clear, a read and an acknowledge. These show that sets win, that reads are not bypassed, and that acknowledge clears only the winner. The shared position is driven from each source alone and from both at once, to show that one acknowledge serves both.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    WM_LOAD = 2'd0,
    WM_SET  = 2'd1,
    WM_CLR  = 2'd2,
    WM_NONE = 2'd3
  } wr_mode_e;

  localparam logic [1:0] BANK_REQ  = 2'd0;
  localparam logic [1:0] BANK_MASK = 2'd1;
  localparam logic [1:0] BANK_PRIO = 2'd2;
  localparam int         WORD_W    = 16;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int NUM_SRC = 32,
  parameter int WIDX_W  = 1,
  parameter logic [NUM_SRC-1:0] RST_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_sel,
  input  logic [WIDX_W-1:0]  wr_word,
  input  logic [1:0]         wr_be,
  input  logic [1:0]         wr_mode,
  input  logic [15:0]        wdata,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic [NUM_SRC-1:0] hw_clr,
  output logic [NUM_SRC-1:0] q
);
  import irqc_pkg::*;
  localparam int NUM_WORDS = NUM_SRC / WORD_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < 2; b++) begin : g_byte
      localparam int LO = w * WORD_W + b * 8;
      logic       hit;
      logic [7:0] sw_val;
      logic [7:0] nxt;

      assign hit = wr_sel && (wr_word == WIDX_W'(w)) && wr_be[b];

      always_comb begin
        sw_val = q[LO +: 8];
        if (hit) begin
          case (wr_mode_e'(wr_mode))
            WM_LOAD: sw_val = wdata[b*8 +: 8];
            WM_SET:  sw_val = q[LO +: 8] | wdata[b*8 +: 8];
            WM_CLR:  sw_val = q[LO +: 8] & ~wdata[b*8 +: 8];
            default: sw_val = q[LO +: 8];
          endcase
        end
        // hardware clear first, hardware set last: a new event is never lost
        nxt = (sw_val & ~hw_clr[LO +: 8]) | hw_set[LO +: 8];
      end

      always_ff @(posedge clk) begin
        if (rst) q[LO +: 8] <= RST_VAL[LO +: 8];
        else     q[LO +: 8] <= nxt;
      end
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] prio,
  output logic               any,
  output logic               any_hi,
  output logic [IDX_W-1:0]   win
);
  logic [NUM_SRC-1:0] hi_pend;
  logic [NUM_SRC-1:0] cand;

  assign hi_pend = pend & prio;
  assign any     = |pend;
  assign any_hi  = |hi_pend;
  assign cand    = any_hi ? hi_pend : pend;

  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) win = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NUM_SRC    = 32,
  parameter int SHARED_IDX = 16,
  parameter int NUM_WORDS  = NUM_SRC / 16,
  parameter int WIDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  parameter int ADDR_W     = WIDX_W + 2,
  parameter int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               evt_alt_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         wr_be_i,
  input  logic [1:0]         wr_mode_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  input  logic               ack_i,
  output logic               irq_o,
  output logic               irq_hi_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic               ack_valid_o,
  output logic [IDX_W-1:0]   ack_idx_o
);
  import irqc_pkg::*;

  logic [1:0]         bank;
  logic [WIDX_W-1:0]  word;
  logic [NUM_SRC-1:0] req_q, mask_q, prio_q;
  logic [NUM_SRC-1:0] req_set, req_clr, pend;
  logic [NUM_SRC-1:0] rd_bank;
  logic [15:0]        rd_word;
  logic               any, any_hi;
  logic [IDX_W-1:0]   win;

  assign bank = addr_i[ADDR_W-1 -: 2];
  assign word = addr_i[WIDX_W-1:0];

  always_comb begin
    req_set = evt_i;
    req_set[SHARED_IDX] = evt_i[SHARED_IDX] | evt_alt_i;
  end

  assign req_clr = (ack_i && any) ? (NUM_SRC'(1) << win) : '0;
  assign pend    = req_q & ~mask_q;

  irqc_flag_bank #(.NUM_SRC(NUM_SRC), .WIDX_W(WIDX_W), .RST_VAL('0)) u_req (
    .clk(clk), .rst(rst), .wr_sel(wr_en_i && bank == BANK_REQ), .wr_word(word),
    .wr_be(wr_be_i), .wr_mode(wr_mode_i), .wdata(wdata_i),
    .hw_set(req_set), .hw_clr(req_clr), .q(req_q));

  irqc_flag_bank #(.NUM_SRC(NUM_SRC), .WIDX_W(WIDX_W), .RST_VAL('1)) u_mask (
    .clk(clk), .rst(rst), .wr_sel(wr_en_i && bank == BANK_MASK), .wr_word(word),
    .wr_be(wr_be_i), .wr_mode(wr_mode_i), .wdata(wdata_i),
    .hw_set('0), .hw_clr('0), .q(mask_q));

  irqc_flag_bank #(.NUM_SRC(NUM_SRC), .WIDX_W(WIDX_W), .RST_VAL('0)) u_prio (
    .clk(clk), .rst(rst), .wr_sel(wr_en_i && bank == BANK_PRIO), .wr_word(word),
    .wr_be(wr_be_i), .wr_mode(wr_mode_i), .wdata(wdata_i),
    .hw_set('0), .hw_clr('0), .q(prio_q));

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .prio(prio_q), .any(any), .any_hi(any_hi), .win(win));

  always_comb begin
    case (bank)
      BANK_REQ:  rd_bank = req_q;
      BANK_MASK: rd_bank = mask_q;
      BANK_PRIO: rd_bank = prio_q;
      default:   rd_bank = '0;
    endcase
    rd_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word == WIDX_W'(w)) rd_word = rd_bank[w*16 +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o     <= '0;
      irq_o       <= 1'b0;
      irq_hi_o    <= 1'b0;
      vec_o       <= '0;
      ack_valid_o <= 1'b0;
      ack_idx_o   <= '0;
    end else begin
      if (rd_en_i) rdata_o <= rd_word;
      irq_o       <= any;
      irq_hi_o    <= any_hi;
      vec_o       <= any ? win : '0;
      ack_valid_o <= ack_i && any;
      if (ack_i && any) ack_idx_o <= win;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int NUM_SRC    = 32,
  parameter int SHARED_IDX = 16,
  parameter int IDX_W      = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               evt_alt_i,
  input logic               wr_en_i,
  input logic               ack_i,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o,
  input logic               irq_hi_o,
  input logic [IDX_W-1:0]   vec_o,
  input logic               ack_valid_o,
  input logic [IDX_W-1:0]   ack_idx_o
);
  logic [NUM_SRC-1:0] set_c, pend_c;

  always_comb begin
    set_c = evt_i;
    set_c[SHARED_IDX] = evt_i[SHARED_IDX] | evt_alt_i;
  end
  assign pend_c = req_q & ~mask_q;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (set_c != '0) |=> ((req_q & $past(set_c)) == $past(set_c))); // R8

  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|pend_c))); // R6

  AST_HI_NEEDS_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq_hi_o |-> irq_o); // R7

  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((($past(pend_c) >> vec_o) & NUM_SRC'(1)) != '0)); // R7

  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    ack_valid_o |-> $past(ack_i)); // R9

  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ack_i && pend_c == '0) |=> !ack_valid_o); // R9

  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (ack_i && pend_c != '0 && set_c == '0 && !wr_en_i) |=> !req_q[ack_idx_o]); // R9
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .SHARED_IDX(SHARED_IDX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .evt_alt_i(evt_alt_i), .wr_en_i(wr_en_i),
  .ack_i(ack_i), .req_q(req_q), .mask_q(mask_q), .irq_o(irq_o), .irq_hi_o(irq_hi_o),
  .vec_o(vec_o), .ack_valid_o(ack_valid_o), .ack_idx_o(ack_idx_o)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] evt_i = '0;
  logic          evt_alt_i = 1'b0;
  logic          rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [1:0]    wr_be_i = '0, wr_mode_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic          ack_i = 1'b0;
  logic          irq_o, irq_hi_o, ack_valid_o;
  logic [4:0]    vec_o, ack_idx_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .evt_alt_i(evt_alt_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_be_i(wr_be_i), .wr_mode_i(wr_mode_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i), .irq_o(irq_o),
    .irq_hi_o(irq_hi_o), .vec_o(vec_o), .ack_valid_o(ack_valid_o), .ack_idx_o(ack_idx_o));

  // {evt[31:0], mask[31:0], prio[31:0], irq, hi, vec[5:0]}
  localparam logic [103:0] VEC [7] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 6'd0},
    {32'h0000_0030, 32'h0000_0000, 32'h0000_0020, 1'b1, 1'b1, 6'd5},
    {32'h8000_0004, 32'h0000_0004, 32'h0000_0000, 1'b1, 1'b0, 6'd31},
    {32'h00F0_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 6'd0},
    {32'h0001_0100, 32'h0000_0000, 32'h0001_0000, 1'b1, 1'b1, 6'd16},
    {32'h0000_0006, 32'h0000_0000, 32'h0000_0006, 1'b1, 1'b1, 6'd1},
    {32'h0000_0300, 32'h0000_0200, 32'h0000_0200, 1'b1, 1'b0, 6'd8}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] bank, input logic w, input logic [1:0] be,
                    input logic [1:0] mode, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = {bank, w}; wr_be_i = be; wr_mode_i = mode; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] bank, input logic w, output logic [15:0] d);
    rd_en_i = 1'b1; addr_i = {bank, w};
    step();
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic wr32(input logic [1:0] bank, input logic [31:0] v);
    wr(bank, 1'b0, 2'b11, 2'd0, v[15:0]);
    wr(bank, 1'b1, 2'b11, 2'd0, v[31:16]);
  endtask

  task automatic ack_chk(input string tag, input logic vld, input logic [4:0] idx);
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
    chk({tag, " ack_valid"}, 32'(ack_valid_o), 32'(vld));
    if (vld) chk({tag, " ack_idx"}, 32'(ack_idx_o), 32'(idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ack_valid", 32'(ack_valid_o), 0);
    rd(2'd0, 1'b0, rv); chk("R1 req w0", 32'(rv), 32'h0000);
    rd(2'd0, 1'b1, rv); chk("R1 req w1", 32'(rv), 32'h0000);
    rd(2'd1, 1'b0, rv); chk("R1 mask w0", 32'(rv), 32'hFFFF);
    rd(2'd1, 1'b1, rv); chk("R1 mask w1", 32'(rv), 32'hFFFF);
    rd(2'd2, 1'b1, rv); chk("R1 prio w1", 32'(rv), 32'h0000);

    // R6 / R7 / R2 / R3 selection vectors
    foreach (VEC[k]) begin
      wr32(2'd0, 32'h0);
      wr32(2'd1, VEC[k][71:40]);
      wr32(2'd2, VEC[k][39:8]);
      evt_i = VEC[k][103:72];
      step();
      evt_i = '0;
      step();
      chk($sformatf("R6 vec%0d irq", k), 32'(irq_o), 32'(VEC[k][7]));
      chk($sformatf("R7 vec%0d hi", k), 32'(irq_hi_o), 32'(VEC[k][6]));
      chk($sformatf("R7 vec%0d idx", k), 32'(vec_o), 32'(VEC[k][5:0]));
    end

    wr32(2'd0, 32'h0); wr32(2'd1, 32'h0); wr32(2'd2, 32'h0);

    // R4 write modes
    wr(2'd0, 1'b0, 2'b11, 2'd1, 16'h0009);
    rd(2'd0, 1'b0, rv); chk("R4 set mode", 32'(rv), 32'h0009);
    wr(2'd0, 1'b0, 2'b11, 2'd2, 16'h0001);
    rd(2'd0, 1'b0, rv); chk("R4 clear mode", 32'(rv), 32'h0008);
    wr(2'd0, 1'b0, 2'b11, 2'd3, 16'hFFFF);
    rd(2'd0, 1'b0, rv); chk("R4 no-change mode", 32'(rv), 32'h0008);

    // R3 byte lanes
    wr(2'd2, 1'b1, 2'b01, 2'd0, 16'hABCD);
    rd(2'd2, 1'b1, rv); chk("R3 low lane", 32'(rv), 32'h00CD);
    wr(2'd2, 1'b1, 2'b10, 2'd0, 16'h1200);
    rd(2'd2, 1'b1, rv); chk("R3 high lane", 32'(rv), 32'h12CD);
    wr(2'd2, 1'b1, 2'b11, 2'd0, 16'h0000);

    // R5 read does not bypass a same-cycle event
    rd_en_i = 1'b1; addr_i = 3'b000; evt_i = 32'h2;
    step();
    rd_en_i = 1'b0; evt_i = '0;
    chk("R5 read before set", 32'(rdata_o), 32'h0008);
    rd(2'd0, 1'b0, rv); chk("R5 read after set", 32'(rv), 32'h000A);

    // R9 acknowledge walks winners, then idle acknowledge
    ack_chk("R9 first", 1'b1, 5'd1);
    rd(2'd0, 1'b0, rv); chk("R9 winner cleared", 32'(rv), 32'h0008);
    ack_chk("R9 second", 1'b1, 5'd3);
    rd(2'd0, 1'b0, rv); chk("R9 all cleared", 32'(rv), 32'h0000);
    chk("R9 irq dropped", 32'(irq_o), 0);
    ack_chk("R9 idle", 1'b0, 5'd0);
    rd(2'd0, 1'b0, rv); chk("R9 idle leaves flags", 32'(rv), 32'h0000);

    // R8 event beats software clear
    evt_i = 32'h4; wr_en_i = 1'b1; addr_i = 3'b000; wr_be_i = 2'b11;
    wr_mode_i = 2'd2; wdata_i = 16'h0004;
    step();
    evt_i = '0; wr_en_i = 1'b0;
    rd(2'd0, 1'b0, rv); chk("R8 set wins", 32'(rv), 32'h0004);

    // R10 event beats acknowledge on the same flag
    ack_i = 1'b1; evt_i = 32'h4;
    step();
    ack_i = 1'b0; evt_i = '0;
    chk("R10 ack_idx", 32'(ack_idx_o), 2);
    rd(2'd0, 1'b0, rv); chk("R10 flag kept", 32'(rv), 32'h0004);
    wr(2'd0, 1'b0, 2'b11, 2'd0, 16'h0000);

    // R2 / R11 shared position
    evt_alt_i = 1'b1;
    step();
    evt_alt_i = 1'b0;
    rd(2'd0, 1'b1, rv); chk("R2 alt source sets shared", 32'(rv), 32'h0001);
    chk("R11 shared vec", 32'(vec_o), 16);
    wr(2'd1, 1'b1, 2'b11, 2'd1, 16'h0001);
    step();
    chk("R11 shared mask", 32'(irq_o), 0);
    wr(2'd1, 1'b1, 2'b11, 2'd2, 16'h0001);
    wr(2'd2, 1'b1, 2'b11, 2'd1, 16'h0001);
    step();
    chk("R11 shared prio", 32'(irq_hi_o), 1);
    ack_chk("R11 shared ack", 1'b1, 5'd16);
    rd(2'd0, 1'b1, rv); chk("R11 shared cleared", 32'(rv), 32'h0000);
    evt_alt_i = 1'b1; evt_i = 32'h0001_0000;
    step();
    evt_alt_i = 1'b0; evt_i = '0;
    ack_chk("R11 both sources", 1'b1, 5'd16);
    rd(2'd0, 1'b1, rv); chk("R11 one ack serves both", 32'(rv), 32'h0000);
    step();
    chk("R11 irq after ack", 32'(irq_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule